// File: doc/BRIEF.md
# Iterative Floating-Point Divide Unit

This unit divides one unpacked floating-point operand by another and returns an unpacked quotient. Each operand arrives as a sign, an unbiased exponent, a two-bit class and a mantissa whose top bit is the hidden one, so a normal mantissa is a value in [1.0, 2.0). The quotient leaves in the same unpacked shape, with two extra bits (guard and round) below the mantissa LSB, a sticky bit and four exception flags. A rounding and packing stage further down the pipe consumes this form. That stage also handles exponent overflow and underflow. Denormal inputs are not accepted.

Operands enter on a valid/ready stream. `in_ready` is high only while the unit is idle. Only a cycle with `in_valid` and `in_ready` both high transfers operands. `in_valid` may stay high while `in_ready` is low; that has no effect, and the operands are taken in the first cycle `in_ready` returns. Results leave on a second valid/ready stream. Once `out_valid` rises, the result is held unchanged until the consumer raises `out_ready`. The unit goes idle in the cycle after that handoff, so it never accepts new operands in the same cycle as a handoff.

The first thing the unit does is sort out the special operand classes: NaN, infinity and zero. Each such case finishes at once, with its own flag where one applies. When both operands are normal, the unit runs a restoring division that yields one quotient bit per cycle. The cycle that accepts the operands is the setup cycle. In it, the unit compares the two mantissas and makes the normalization decision, and that decision fixes the exponent before the first iteration.

Top module: `fdiv_iter`

## Requirements
- R1: `in_ready` is 1 only when the unit is idle: after reset, and from the cycle after a result handoff until operands are accepted. Operands transfer only in a cycle with `in_valid` and `in_ready` both 1. `in_valid` asserted while `in_ready` is 0 has no effect and produces no result.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every result field stays unchanged in the next cycle. After a handoff cycle (`out_valid` and `out_ready` both 1), `out_valid` is 0 and `in_ready` is 1.
- R3: If operands are accepted in cycle c, `out_valid` first rises in cycle c+1 for a special case. For a normal/normal divide it first rises in cycle c+1+Q_W, where Q_W = MANT_W+2 (26 by default).
- R4: For normal/normal operands with mantissas A and B, `res_cls` is normal (1) and `res_mant` is the Q_W-bit quotient, truncated: floor(A·2^(Q_W-1)/B) when A ≥ B, else floor(A·2^Q_W/B). Its top bit is always 1.
- R5: For normal/normal operands, `res_exp` is a_exp − b_exp when A ≥ B and a_exp − b_exp − 1 when A < B, modulo 2^EXP_W.
- R6: For normal/normal operands, `res_sticky` is 1 exactly when the division in R4 leaves a nonzero remainder. It is 0 for every special-case result.
- R7: Every result whose class is not NaN carries `res_sign` = a_sign XOR b_sign.
- R8: Class codes are zero = 0, normal = 1, infinity = 2, NaN = 3. A NaN is signalling when bit MANT_W−2 of its mantissa is 0. If either operand is NaN, the result is an operand NaN with flag bit 0 (signalling-NaN invalid) set. The chosen NaN is the only NaN operand when just one is a NaN. When both are NaN, it is the dividend if the dividend is signalling and the divisor is quiet, and the divisor otherwise. The result copies that operand's sign and exponent, and its mantissa is `{mant, 2'b00}`.
- R9: Infinity/infinity sets flag bit 1 and zero/zero sets flag bit 2. Both return the default NaN: sign 0, exponent 0, mantissa with its two top bits 1 and the rest 0.
- R10: Infinity divided by normal or zero gives infinity. Zero divided by normal or infinity gives zero. Normal divided by infinity gives zero. These results have no flags, exponent 0 and mantissa 0.
- R11: Normal divided by zero gives infinity with flag bit 3 (divide by zero), exponent 0 and mantissa 0. Normal/normal results have all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle, operands will be taken |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EXP_W | Dividend unbiased exponent |
| a_cls | input | 2 | Dividend class |
| a_mant | input | MANT_W | Dividend mantissa, hidden bit at top |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EXP_W | Divisor unbiased exponent |
| b_cls | input | 2 | Divisor class |
| b_mant | input | MANT_W | Divisor mantissa, hidden bit at top |
| out_valid | output | 1 | Result held and valid |
| out_ready | input | 1 | Consumer takes the result |
| res_sign | output | 1 | Quotient sign |
| res_exp | output | EXP_W | Quotient exponent |
| res_cls | output | 2 | Quotient class |
| res_mant | output | MANT_W+2 | Quotient mantissa with guard and round |
| res_sticky | output | 1 | Bits lost below round |
| res_flags | output | 4 | Exception flags (bit 0 sNaN, 1 inf/inf, 2 zero/zero, 3 divide by zero) |

## Verification
A result handoff and a new operand request can land in the same cycle. This happens when the producer keeps `in_valid` high through the whole divide. Back-to-back requests are issued with the consumer throttling `out_ready`, so that `in_valid` is already high in every handoff cycle. The scoreboard then checks three things: the pending request is taken one cycle later, its result shows up at the R3 latency counted from that later cycle, and the held result stays unchanged while stalled. Operands offered during a busy divide are checked to leave no trace: the number of results must equal the number of accepted requests, in order.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [1:0] {
    FC_ZERO = 2'd0,
    FC_NORM = 2'd1,
    FC_INF  = 2'd2,
    FC_NAN  = 2'd3
  } fcls_e;

  localparam int FLG_W         = 4;
  localparam int FLG_SNAN      = 0;
  localparam int FLG_INF_INF   = 1;
  localparam int FLG_ZERO_ZERO = 2;
  localparam int FLG_DIV0      = 3;

endpackage

// File: rtl/fdiv_special.sv
// Resolves every operand combination that does not need the iterative divider.
module fdiv_special
  import fdiv_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 10,
  parameter int GRD    = 2,
  localparam int Q_W   = MANT_W + GRD
) (
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  fcls_e             a_cls,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  fcls_e             b_cls,
  input  logic [MANT_W-1:0] b_mant,
  output logic              sp_hit,
  output logic              sp_sign,
  output logic [EXP_W-1:0]  sp_exp,
  output fcls_e             sp_cls,
  output logic [Q_W-1:0]    sp_mant,
  output logic [FLG_W-1:0]  sp_flags
);

  localparam int QUIET_BIT = MANT_W - 2;
  localparam logic [Q_W-1:0] DEF_NAN_MANT = {2'b11, {(Q_W-2){1'b0}}};

  logic a_nan, b_nan, a_sig, b_sig, take_a, xs;

  assign a_nan  = (a_cls == FC_NAN);
  assign b_nan  = (b_cls == FC_NAN);
  assign a_sig  = a_nan & ~a_mant[QUIET_BIT];
  assign b_sig  = b_nan & ~b_mant[QUIET_BIT];
  assign take_a = a_nan & (~b_nan | (a_sig & ~b_sig));
  assign xs     = a_sign ^ b_sign;

  always_comb begin
    sp_hit   = 1'b1;
    sp_sign  = xs;
    sp_exp   = '0;
    sp_cls   = FC_ZERO;
    sp_mant  = '0;
    sp_flags = '0;
    if (a_nan || b_nan) begin
      sp_cls             = FC_NAN;
      sp_flags[FLG_SNAN] = 1'b1;
      if (take_a) begin
        sp_sign = a_sign;
        sp_exp  = a_exp;
        sp_mant = {a_mant, {GRD{1'b0}}};
      end else begin
        sp_sign = b_sign;
        sp_exp  = b_exp;
        sp_mant = {b_mant, {GRD{1'b0}}};
      end
    end else if (a_cls == FC_INF) begin
      if (b_cls == FC_INF) begin
        sp_cls                = FC_NAN;
        sp_sign               = 1'b0;
        sp_mant               = DEF_NAN_MANT;
        sp_flags[FLG_INF_INF] = 1'b1;
      end else begin
        sp_cls = FC_INF;
      end
    end else if (a_cls == FC_ZERO) begin
      if (b_cls == FC_ZERO) begin
        sp_cls                  = FC_NAN;
        sp_sign                 = 1'b0;
        sp_mant                 = DEF_NAN_MANT;
        sp_flags[FLG_ZERO_ZERO] = 1'b1;
      end else begin
        sp_cls = FC_ZERO;
      end
    end else if (b_cls == FC_INF) begin
      sp_cls = FC_ZERO;
    end else if (b_cls == FC_ZERO) begin
      sp_cls             = FC_INF;
      sp_flags[FLG_DIV0] = 1'b1;
    end else begin
      sp_hit = 1'b0;
    end
  end

  // R9/R11: a special result never raises more than one flag
  always_comb begin
    assert ($onehot0(sp_flags)) else $error("p_flag_single_r9");
  end

endmodule

// File: rtl/fdiv_mant_core.sv
// Restoring mantissa divider: one quotient bit per cycle, MSB first.
module fdiv_mant_core #(
  parameter int MANT_W = 24,
  parameter int GRD    = 2,
  localparam int Q_W   = MANT_W + GRD,
  localparam int R_W   = MANT_W + 1,
  localparam int CNT_W = $clog2(Q_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MANT_W-1:0] dvd,
  input  logic [MANT_W-1:0] dvs,
  output logic              lt,
  output logic              fin,
  output logic [Q_W-1:0]    quo,
  output logic              rem_nz
);

  logic [R_W-1:0]   rem;
  logic [MANT_W-1:0] ydiv;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [R_W:0]     diff;
  logic             ge;
  logic [R_W-1:0]   kept;

  // Normalization decision taken in the setup cycle
  assign lt   = (dvd < dvs);
  assign run  = (cnt != '0);
  assign fin  = run && (cnt == CNT_W'(1));

  assign diff = {1'b0, rem} - {2'b00, ydiv};
  assign ge   = ~diff[R_W];
  assign kept = ge ? diff[R_W-1:0] : rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      ydiv <= '0;
      cnt  <= '0;
      quo  <= '0;
    end else if (load) begin
      rem  <= lt ? {dvd, 1'b0} : {1'b0, dvd};
      ydiv <= dvs;
      cnt  <= CNT_W'(Q_W);
      quo  <= '0;
    end else if (run) begin
      rem  <= kept << 1;
      quo  <= {quo[Q_W-2:0], ge};
      cnt  <= cnt - CNT_W'(1);
    end
  end

  assign rem_nz = (rem != '0);

  // R4: partial remainder always stays below twice the divisor
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem < {ydiv, 1'b0}));

  // R4: the first iteration always yields a one
  p_first_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == CNT_W'(Q_W)) |-> (rem >= {1'b0, ydiv}));

endmodule

// File: rtl/fdiv_iter.sv
module fdiv_iter
  import fdiv_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 10,
  localparam int GRD   = 2,
  localparam int Q_W   = MANT_W + GRD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [1:0]        a_cls,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [1:0]        b_cls,
  input  logic [MANT_W-1:0] b_mant,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              res_sign,
  output logic [EXP_W-1:0]  res_exp,
  output logic [1:0]        res_cls,
  output logic [Q_W-1:0]    res_mant,
  output logic              res_sticky,
  output logic [FLG_W-1:0]  res_flags
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;

  st_e              st;
  logic             take;
  logic             sp_hit, sp_sign;
  logic [EXP_W-1:0] sp_exp;
  fcls_e            sp_cls;
  logic [Q_W-1:0]   sp_mant;
  logic [FLG_W-1:0] sp_flags;

  logic             core_lt, core_fin, core_rem_nz, core_load;
  logic [Q_W-1:0]   core_quo;

  logic             r_sign, r_norm;
  logic [EXP_W-1:0] r_exp;
  fcls_e            r_cls;
  logic [Q_W-1:0]   r_mant;
  logic [FLG_W-1:0] r_flags;

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_DONE);
  assign take      = in_valid && in_ready;
  assign core_load = take && !sp_hit;

  fdiv_special #(.MANT_W(MANT_W), .EXP_W(EXP_W), .GRD(GRD)) u_special (
    .a_sign  (a_sign),
    .a_exp   (a_exp),
    .a_cls   (fcls_e'(a_cls)),
    .a_mant  (a_mant),
    .b_sign  (b_sign),
    .b_exp   (b_exp),
    .b_cls   (fcls_e'(b_cls)),
    .b_mant  (b_mant),
    .sp_hit  (sp_hit),
    .sp_sign (sp_sign),
    .sp_exp  (sp_exp),
    .sp_cls  (sp_cls),
    .sp_mant (sp_mant),
    .sp_flags(sp_flags)
  );

  fdiv_mant_core #(.MANT_W(MANT_W), .GRD(GRD)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (core_load),
    .dvd   (a_mant),
    .dvs   (b_mant),
    .lt    (core_lt),
    .fin   (core_fin),
    .quo   (core_quo),
    .rem_nz(core_rem_nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (take) st <= sp_hit ? S_DONE : S_RUN;
        S_RUN:   if (core_fin) st <= S_DONE;
        S_DONE:  if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sign  <= 1'b0;
      r_norm  <= 1'b0;
      r_exp   <= '0;
      r_cls   <= FC_ZERO;
      r_mant  <= '0;
      r_flags <= '0;
    end else if (take) begin
      if (sp_hit) begin
        r_sign  <= sp_sign;
        r_norm  <= 1'b0;
        r_exp   <= sp_exp;
        r_cls   <= sp_cls;
        r_mant  <= sp_mant;
        r_flags <= sp_flags;
      end else begin
        r_sign  <= a_sign ^ b_sign;
        r_norm  <= 1'b1;
        r_exp   <= a_exp - b_exp - {{(EXP_W-1){1'b0}}, core_lt};
        r_cls   <= FC_NORM;
        r_mant  <= '0;
        r_flags <= '0;
      end
    end
  end

  assign res_sign   = r_sign;
  assign res_exp    = r_exp;
  assign res_cls    = r_cls;
  assign res_mant   = r_norm ? core_quo : r_mant;
  assign res_sticky = r_norm & core_rem_nz;
  assign res_flags  = r_flags;

  // R1: never ready while a result is outstanding
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R2: a stalled result holds still
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_mant) && $stable(res_exp)
                                   && $stable(res_cls) && $stable(res_sticky)
                                   && $stable(res_flags) && $stable(res_sign)));

  // R2: handoff returns the unit to idle
  p_handoff_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R3: special cases finish in the next cycle
  p_special_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sp_hit) |=> out_valid);

  // R4: a normal quotient is normalized
  p_norm_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_cls == FC_NORM) |-> res_mant[Q_W-1]);

  // R11: flags stay clear for normal quotients, at most one otherwise
  p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($onehot0(res_flags) && (res_cls != FC_NORM || res_flags == '0)));

endmodule

// File: tb/tb_fdiv_iter.sv
module tb_fdiv_iter;

  localparam int MANT_W = 24;
  localparam int EXP_W  = 10;
  localparam int Q_W    = MANT_W + 2;
  localparam int LIMIT  = 100000;

  typedef struct {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [1:0]       cls;
    logic [Q_W-1:0]   mant;
    logic             sticky;
    logic [3:0]       flags;
    int               due;
    bit               special;
    string            tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
  logic [1:0] a_cls = 2'd0, b_cls = 2'd0;
  logic [MANT_W-1:0] a_mant = '0, b_mant = '0;
  logic res_sign, res_sticky;
  logic [EXP_W-1:0] res_exp;
  logic [1:0] res_cls;
  logic [Q_W-1:0] res_mant;
  logic [3:0] res_flags;

  int checks = 0, fails = 0, cyc = 0;
  int sent = 0, got = 0;
  bit bp_en = 1'b0, seen = 1'b0, held = 1'b0, done_flag = 1'b0;
  item_t sb[$];
  logic [Q_W+EXP_W+8:0] snap;

  always #4 clk = ~clk;

  fdiv_iter #(.MANT_W(MANT_W), .EXP_W(EXP_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_sign(a_sign), .a_exp(a_exp), .a_cls(a_cls), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_cls(b_cls), .b_mant(b_mant),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_sign(res_sign), .res_exp(res_exp), .res_cls(res_cls),
    .res_mant(res_mant), .res_sticky(res_sticky), .res_flags(res_flags));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected result built from the requirements
  function automatic item_t model(logic as, logic [EXP_W-1:0] ae, logic [1:0] ac, logic [MANT_W-1:0] am,
                                  logic bs, logic [EXP_W-1:0] be, logic [1:0] bc, logic [MANT_W-1:0] bm);
    item_t it;
    bit an, bn, asg, bsg;
    longint unsigned num;
    it.sign = as ^ bs; it.exp = '0; it.mant = '0; it.sticky = 1'b0; it.flags = '0;
    it.special = 1'b1; it.due = 0; it.cls = 2'd0; it.tag = "R10";
    an = (ac == 2'd3); bn = (bc == 2'd3);
    asg = an && !am[MANT_W-2]; bsg = bn && !bm[MANT_W-2];
    if (an || bn) begin
      it.tag = "R8"; it.cls = 2'd3; it.flags = 4'b0001;
      if (an && (!bn || (asg && !bsg))) begin
        it.sign = as; it.exp = ae; it.mant = {am, 2'b00};
      end else begin
        it.sign = bs; it.exp = be; it.mant = {bm, 2'b00};
      end
    end else if (ac == 2'd2 && bc == 2'd2) begin
      it.tag = "R9"; it.cls = 2'd3; it.sign = 0; it.mant = {2'b11, {(Q_W-2){1'b0}}}; it.flags = 4'b0010;
    end else if (ac == 2'd0 && bc == 2'd0) begin
      it.tag = "R9"; it.cls = 2'd3; it.sign = 0; it.mant = {2'b11, {(Q_W-2){1'b0}}}; it.flags = 4'b0100;
    end else if (ac == 2'd2) begin
      it.cls = 2'd2;
    end else if (ac == 2'd0 || bc == 2'd2) begin
      it.cls = 2'd0;
    end else if (bc == 2'd0) begin
      it.tag = "R11"; it.cls = 2'd2; it.flags = 4'b1000;
    end else begin
      it.tag = "R4"; it.cls = 2'd1; it.special = 1'b0;
      num = (am >= bm) ? (longint'(am) << (Q_W-1)) : (longint'(am) << Q_W);
      it.mant = Q_W'(num / bm);
      it.sticky = (num % bm) != 0;
      it.exp = ae - be - ((am < bm) ? 1 : 0);
    end
    return it;
  endfunction

  task automatic send(logic as, logic [EXP_W-1:0] ae, logic [1:0] ac, logic [MANT_W-1:0] am,
                      logic bs, logic [EXP_W-1:0] be, logic [1:0] bc, logic [MANT_W-1:0] bm);
    item_t it;
    it = model(as, ae, ac, am, bs, be, bc, bm);
    @(negedge clk);
    a_sign = as; a_exp = ae; a_cls = ac; a_mant = am;
    b_sign = bs; b_exp = be; b_cls = bc; b_mant = bm;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    it.due = cyc + (it.special ? 1 : Q_W + 1);
    sb.push_back(it);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R1: offer junk while busy; it must be ignored
  task automatic poke_busy(int n);
    for (int i = 0; i < n; i++) begin
      check(!in_ready, "R1", "in_ready while busy", 64'(in_ready), 64'd0);
      a_cls = 2'd3; b_cls = 2'd0; a_mant = '1; in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Monitor: drives out_ready and pops the scoreboard on each handoff
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(out_valid && snap == {res_sign, res_exp, res_cls, res_mant, res_sticky, res_flags},
              "R2", "held result", 64'(out_valid), 64'd1);
        held = 1'b0;
      end
      out_ready = bp_en ? ((cyc % 3) == 2) : 1'b1;
      if (out_valid && !seen) begin
        seen = 1'b1;
        if (sb.size() == 0) check(1'b0, "R1", "unexpected result", 64'd1, 64'd0);
        else check(cyc == sb[0].due, "R3", "latency cycle", 64'(cyc), 64'(sb[0].due));
      end
      if (out_valid && !out_ready) begin
        held = 1'b1;
        snap = {res_sign, res_exp, res_cls, res_mant, res_sticky, res_flags};
      end
      if (out_valid && out_ready && sb.size() != 0) begin
        item_t e;
        e = sb.pop_front();
        got++;
        seen = 1'b0;
        check(res_cls == e.cls, e.tag, "class", 64'(res_cls), 64'(e.cls));
        check(res_mant == e.mant, (e.tag == "R4") ? "R4" : e.tag, "mantissa", 64'(res_mant), 64'(e.mant));
        check(res_exp == e.exp, e.special ? e.tag : "R5", "exponent", 64'(res_exp), 64'(e.exp));
        check(res_sticky == e.sticky, "R6", "sticky", 64'(res_sticky), 64'(e.sticky));
        check(res_sign == e.sign, "R7", "sign", 64'(res_sign), 64'(e.sign));
        check(res_flags == e.flags, e.special ? e.tag : "R11", "flags", 64'(res_flags), 64'(e.flags));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !done_flag) begin
      done_flag = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [MANT_W-1:0] ONE  = 24'h800000;
  localparam logic [MANT_W-1:0] ONE5 = 24'hC00000;
  localparam logic [MANT_W-1:0] MAXM = 24'hFFFFFF;
  localparam logic [MANT_W-1:0] QNAN = 24'hC00001;
  localparam logic [MANT_W-1:0] SNAN = 24'h800001;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "reset in_ready", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R2", "reset out_valid", 64'(out_valid), 64'd0);

    // R4 R5 R6: normal divides, both orderings of mantissa size
    send(0, 10'd5, 2'd1, ONE, 0, 10'd2, 2'd1, ONE);
    send(1, 10'd0, 2'd1, ONE5, 0, 10'd0, 2'd1, ONE);
    send(0, 10'd3, 2'd1, ONE, 1, 10'd7, 2'd1, ONE5);
    poke_busy(5);
    send(1, 10'h3FF, 2'd1, MAXM, 1, 10'd1, 2'd1, ONE);
    send(0, 10'd0, 2'd1, ONE, 0, 10'h200, 2'd1, MAXM);
    for (int i = 0; i < 6; i++)
      send(1'($urandom), 10'($urandom), 2'd1, 24'($urandom) | ONE,
           1'($urandom), 10'($urandom), 2'd1, 24'($urandom) | ONE);

    // R8: NaN operand choices
    send(1, 10'd4, 2'd3, QNAN, 0, 10'd1, 2'd1, ONE);
    send(0, 10'd2, 2'd1, ONE, 1, 10'd6, 2'd3, SNAN);
    send(1, 10'd9, 2'd3, SNAN, 0, 10'd8, 2'd3, QNAN);
    send(1, 10'd9, 2'd3, QNAN, 0, 10'd8, 2'd3, QNAN);
    send(0, 10'd9, 2'd3, SNAN, 1, 10'd8, 2'd3, SNAN);
    // R9 R10 R11: remaining special combinations
    send(1, 10'd0, 2'd2, 0, 0, 10'd0, 2'd2, 0);
    send(0, 10'd0, 2'd0, 0, 1, 10'd0, 2'd0, 0);
    send(1, 10'd0, 2'd2, 0, 0, 10'd3, 2'd1, ONE);
    send(0, 10'd0, 2'd2, 0, 1, 10'd0, 2'd0, 0);
    send(1, 10'd0, 2'd0, 0, 1, 10'd3, 2'd1, ONE);
    send(0, 10'd0, 2'd0, 0, 1, 10'd0, 2'd2, 0);
    send(0, 10'd3, 2'd1, ONE5, 1, 10'd0, 2'd2, 0);
    send(1, 10'd3, 2'd1, ONE5, 0, 10'd0, 2'd0, 0);

    // R2 R3: back-pressure with requests waiting at every handoff
    bp_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send(0, 10'd1, 2'd1, 24'($urandom) | ONE, 1, 10'd2, 2'd1, 24'($urandom) | ONE);
      send(1, 10'd0, 2'd0, 0, 0, 10'd0, 2'd1, ONE);
    end
    while (sb.size() != 0) @(negedge clk);
    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    check(got == sent, "R1", "result count", 64'(got), 64'(sent));
    check(in_ready == 1'b1, "R2", "idle after drain", 64'(in_ready), 64'd1);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule